// File: doc/BRIEF.md
# Processor Status Word and Banked Stack Pointer Unit

This block keeps the processor status word together with the active stack pointer and three stored stack pointer banks: user, interrupt and master. The supervisor and master bits of the status word choose which bank is live. All status and control registers share one register-file style port, and the condition flags have a separate update path that the execution datapath drives.

A two-bit core kind input selects between a narrow and a wide flavour. It sets which status bits can be written and how many address bits the program counter keeps. Instruction decoding and arithmetic are not part of this block.

After reset the unit enters supervisor mode on the interrupt bank. It then fetches two 32-bit words over a simple request/acknowledge read interface: the first is the initial stack pointer and the second is the initial program counter. It raises its run indication only after both fetches have completed.

Top module: `psw_stack_unit`

## Requirements
- R1: While reset is held and on the first cycle after it is released, status_word reads 0x2700 (trace bits clear, supervisor set, master clear, interrupt mask 7), the vector base register reads 0, run_mode is low, and a fetch is requested from address 0.
- R2: The reset fetch reads address 0 first and loads that word into the active stack pointer, then reads address 4 and loads that word into the program counter. The request and its address hold while mem_ack is low. run_mode rises only on the cycle after the second acknowledge.
- R3: The program counter loaded by the reset fetch keeps its low 24 bits for core_kind 0, 1 and 2, and all 32 bits for core_kind 3.
- R4: While run_mode is low, register writes and flag updates have no effect.
- R5: A write to the status word stores the written value ANDed with 0xA71F when core_kind is 0 or 1, and with 0xF71F when core_kind is 2 or 3. Bits 11 and 7:5 always read 0.
- R6: flag_we replaces status bits 4:0 with flag_in and leaves the other bits unchanged. A status word write in the same cycle takes precedence over the flag update.
- R7: An access to the user stack pointer reaches the stored user bank when S=1 and the live stack pointer when S=0.
- R8: An access to the interrupt stack pointer reaches the live stack pointer when S=1 and M=0, and the stored bank otherwise. An access to the master stack pointer reaches the live stack pointer when S=1 and M=1, and the stored bank otherwise.
- R9: A status write that changes the selected bank saves the live stack pointer into the bank being left and loads the live stack pointer from the bank being entered, both in the same cycle.
- R10: The source and destination function code registers store only bits 2:0 of the written value and read back zero-extended.
- R11: reg_sel encodes 0 live stack pointer, 1 user, 2 interrupt, 3 master, 4 vector base, 5 source function code, 6 destination function code, 7 status word (low 16 bits). reg_rdata shows the register selected in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_kind | input | 2 | Core flavour: 0/1 narrow, 2 wide status with 24-bit address, 3 wide with 32-bit address |
| reg_sel | input | 3 | Register select for read and write |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the previous selection |
| flag_we | input | 1 | Condition flag update enable |
| flag_in | input | 5 | New X, N, Z, V, C flags (bits 4:0) |
| status_word | output | 16 | Current status word |
| active_sp | output | 32 | Live stack pointer |
| prog_ctr | output | 32 | Program counter loaded at reset |
| run_mode | output | 1 | High once both reset fetches have completed |
| mem_req | output | 1 | Fetch request |
| mem_addr | output | 32 | Fetch address |
| mem_rdata | input | 32 | Fetch return data |
| mem_ack | input | 1 | Fetch acknowledge; data is taken in this cycle |

## Verification
The hardest situation to reach is a bank swap in which the live stack pointer and every stored bank hold distinct values. Only then does a wrong save or load direction show up at active_sp or on a named read. The stimulus first writes a different value into each bank through the named-pointer selects, using the live select for the active bank, and then moves the status word through interrupt, master and user modes. After every move it checks active_sp and reads the banks it has just left. A last status write under a narrow core kind shows that masking M away sends the unit back to the interrupt bank.

// File: rtl/psw_pkg.sv
package psw_pkg;

  typedef enum logic [1:0] {
    BANK_USER = 2'd0,
    BANK_INTR = 2'd1,
    BANK_MAST = 2'd2
  } bank_t;

  localparam int NBANK = 3;

  typedef enum logic [2:0] {
    SEL_LIVE = 3'd0,
    SEL_USP  = 3'd1,
    SEL_ISP  = 3'd2,
    SEL_MSP  = 3'd3,
    SEL_VBR  = 3'd4,
    SEL_SFC  = 3'd5,
    SEL_DFC  = 3'd6,
    SEL_STAT = 3'd7
  } sel_t;

  typedef enum logic [1:0] {
    FS_SP  = 2'd0,
    FS_PC  = 2'd1,
    FS_RUN = 2'd2
  } fstate_t;

  localparam int          SR_BIT_S      = 13;
  localparam int          SR_BIT_M      = 12;
  localparam logic [15:0] SR_WMASK_NARROW = 16'hA71F;
  localparam logic [15:0] SR_WMASK_WIDE   = 16'hF71F;
  localparam logic [15:0] SR_AT_RESET     = 16'h2700;

  function automatic bank_t bank_of(input logic s, input logic m);
    if (!s)      return BANK_USER;
    else if (!m) return BANK_INTR;
    else         return BANK_MAST;
  endfunction

endpackage

// File: rtl/psw_boot_fetch.sv
module psw_boot_fetch
  import psw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          run_mode,
  output logic          sp_load,
  output logic          pc_load
);

  localparam logic [AW-1:0] SP_VEC_ADDR = '0;
  localparam logic [AW-1:0] PC_VEC_ADDR = AW'(WORD_BYTES);

  fstate_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= FS_SP;
    end else begin
      case (st_q)
        FS_SP:   if (mem_ack) st_q <= FS_PC;
        FS_PC:   if (mem_ack) st_q <= FS_RUN;
        default: st_q <= FS_RUN;
      endcase
    end
  end

  assign mem_req  = (st_q != FS_RUN);
  assign mem_addr = (st_q == FS_PC) ? PC_VEC_ADDR : SP_VEC_ADDR;
  assign run_mode = (st_q == FS_RUN);
  assign sp_load  = (st_q == FS_SP) && mem_ack;
  assign pc_load  = (st_q == FS_PC) && mem_ack;

endmodule

// File: rtl/psw_sp_bank.sv
module psw_sp_bank
  import psw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [DW-1:0] ld_data,
  input  logic          swap_en,
  input  bank_t         from_bank,
  input  bank_t         to_bank,
  input  logic          wr_en,
  input  logic          wr_to_live,
  input  bank_t         wr_bank,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] live_q,
  output logic [DW-1:0] sh_q [NBANK]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
    end else if (ld_en) begin
      live_q <= ld_data;
    end else if (swap_en) begin
      live_q <= sh_q[to_bank];
    end else if (wr_en && wr_to_live) begin
      live_q <= wr_data;
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) begin
        r <= '0;
      end else if (!ld_en && swap_en && from_bank == bank_t'(g)) begin
        r <= live_q;
      end else if (!ld_en && !swap_en && wr_en && !wr_to_live && wr_bank == bank_t'(g)) begin
        r <= wr_data;
      end
    end
    assign sh_q[g] = r;
  end

endmodule

// File: rtl/psw_stack_unit.sv
module psw_stack_unit
  import psw_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 32,
  parameter int SRW       = 16,
  parameter int FCW       = 3,
  parameter int CCW       = 5,
  parameter int NARROW_AW = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     core_kind,
  input  logic [2:0]     reg_sel,
  input  logic           reg_we,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           flag_we,
  input  logic [CCW-1:0] flag_in,
  output logic [SRW-1:0] status_word,
  output logic [DW-1:0]  active_sp,
  output logic [AW-1:0]  prog_ctr,
  output logic           run_mode,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack
);

  localparam logic [AW-1:0] AMASK_NARROW = {{(AW-NARROW_AW){1'b0}}, {NARROW_AW{1'b1}}};
  localparam logic [AW-1:0] AMASK_FULL   = '1;

  logic           sp_load, pc_load;
  logic [SRW-1:0] sr_q;
  logic [DW-1:0]  vbr_q, rdata_q, rd_mux;
  logic [FCW-1:0] sfc_q, dfc_q;
  logic [AW-1:0]  pc_q;
  logic [DW-1:0]  live_sp;
  logic [DW-1:0]  shadow [NBANK];

  psw_boot_fetch #(.AW(AW), .WORD_BYTES(DW/8)) u_fetch (
    .clk(clk), .rst(rst), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .run_mode(run_mode),
    .sp_load(sp_load), .pc_load(pc_load)
  );

  sel_t           sel;
  logic           wr_ok, sr_we, sp_we, is_named, wr_to_live, swap;
  logic [SRW-1:0] sr_mask, sr_wval;
  logic [AW-1:0]  addr_mask;
  bank_t          cur_bank, new_bank, named_bank;

  always_comb begin
    sel        = sel_t'(reg_sel);
    wr_ok      = reg_we && run_mode;
    sr_mask    = core_kind[1] ? SR_WMASK_WIDE : SR_WMASK_NARROW;
    addr_mask  = (core_kind == 2'd3) ? AMASK_FULL : AMASK_NARROW;
    sr_wval    = reg_wdata[SRW-1:0] & sr_mask;
    sr_we      = wr_ok && (sel == SEL_STAT);
    cur_bank   = bank_of(sr_q[SR_BIT_S], sr_q[SR_BIT_M]);
    new_bank   = bank_of(sr_wval[SR_BIT_S], sr_wval[SR_BIT_M]);
    swap       = sr_we && (new_bank != cur_bank);
    is_named   = sel inside {SEL_USP, SEL_ISP, SEL_MSP};
    named_bank = bank_t'(reg_sel[1:0] - 2'd1);
    sp_we      = wr_ok && (sel == SEL_LIVE || is_named);
    wr_to_live = (sel == SEL_LIVE) || (named_bank == cur_bank);
  end

  psw_sp_bank #(.DW(DW)) u_bank (
    .clk(clk), .rst(rst),
    .ld_en(sp_load), .ld_data(mem_rdata),
    .swap_en(swap), .from_bank(cur_bank), .to_bank(new_bank),
    .wr_en(sp_we), .wr_to_live(wr_to_live), .wr_bank(named_bank), .wr_data(reg_wdata),
    .live_q(live_sp), .sh_q(shadow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= SR_AT_RESET;
    end else if (sr_we) begin
      sr_q <= sr_wval;
    end else if (flag_we && run_mode) begin
      sr_q[CCW-1:0] <= flag_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbr_q <= '0;
      sfc_q <= '0;
      dfc_q <= '0;
      pc_q  <= '0;
    end else begin
      if (wr_ok && sel == SEL_VBR) vbr_q <= reg_wdata;
      if (wr_ok && sel == SEL_SFC) sfc_q <= reg_wdata[FCW-1:0];
      if (wr_ok && sel == SEL_DFC) dfc_q <= reg_wdata[FCW-1:0];
      if (pc_load)                 pc_q  <= mem_rdata[AW-1:0] & addr_mask;
    end
  end

  always_comb begin
    case (sel)
      SEL_LIVE: rd_mux = live_sp;
      SEL_USP, SEL_ISP, SEL_MSP:
                rd_mux = (named_bank == cur_bank) ? live_sp : shadow[named_bank];
      SEL_VBR:  rd_mux = vbr_q;
      SEL_SFC:  rd_mux = {{(DW-FCW){1'b0}}, sfc_q};
      SEL_DFC:  rd_mux = {{(DW-FCW){1'b0}}, dfc_q};
      default:  rd_mux = {{(DW-SRW){1'b0}}, sr_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign reg_rdata   = rdata_q;
  assign status_word = sr_q;
  assign active_sp   = live_sp;
  assign prog_ctr    = pc_q;

endmodule

// File: rtl/psw_stack_unit_chk.sv
module psw_stack_unit_chk #(
  parameter int DW  = 32,
  parameter int AW  = 32,
  parameter int SRW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [SRW-1:0] status_word,
  input logic [DW-1:0]  active_sp,
  input logic           run_mode,
  input logic           mem_req,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_rdata,
  input logic           mem_ack
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status_word == 16'h2700) && !run_mode && mem_req && (mem_addr == '0));

  // R2
  run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    run_mode |=> run_mode);

  // R2
  fetch_pending_chk: assert property (@(posedge clk) disable iff (rst)
    !run_mode |-> mem_req && (mem_addr == '0 || mem_addr == AW'(4)));

  // R2
  sp_fetch_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && mem_addr == '0) |=> (active_sp == $past(mem_rdata)));

  // R4
  frozen_status_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_mode && !$past(rst)) |-> $stable(status_word));

  // R5
  reserved_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (status_word & ~16'hF71F) == '0);

endmodule

bind psw_stack_unit psw_stack_unit_chk #(.DW(DW), .AW(AW), .SRW(SRW)) u_chk (
  .clk(clk), .rst(rst), .status_word(status_word), .active_sp(active_sp),
  .run_mode(run_mode), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rdata(mem_rdata), .mem_ack(mem_ack)
);

// File: tb/psw_stack_unit_test.sv
module psw_stack_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  core_kind;
  logic [2:0]  reg_sel;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        flag_we;
  logic [4:0]  flag_in;
  logic [15:0] status_word;
  logic [31:0] active_sp;
  logic [31:0] prog_ctr;
  logic        run_mode;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        mem_ack;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  psw_stack_unit uut (
    .clk(clk), .rst(rst), .core_kind(core_kind),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flag_we(flag_we), .flag_in(flag_in), .status_word(status_word),
    .active_sp(active_sp), .prog_ctr(prog_ctr), .run_mode(run_mode),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // {core_kind, written status, expected status}
  localparam logic [33:0] VEC [6] = '{
    {2'd0, 16'hFFFF, 16'hA71F},
    {2'd1, 16'hF0F0, 16'hA010},
    {2'd2, 16'hFFFF, 16'hF71F},
    {2'd3, 16'h5A5A, 16'h521A},
    {2'd0, 16'h3700, 16'h2700},
    {2'd3, 16'h0000, 16'h0000}
  };

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = data;
    tick;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] data);
    reg_sel = sel;
    tick;
    data = reg_rdata;
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (3) tick;
    rst = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] sp, input logic [31:0] pc);
    mem_ack = 1'b1; mem_rdata = sp;
    tick;
    mem_rdata = pc;
    tick;
    mem_ack = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    rst = 1'b1; core_kind = 2'd0; reg_sel = '0; reg_we = 1'b0; reg_wdata = '0;
    flag_we = 1'b0; flag_in = '0; mem_rdata = '0; mem_ack = 1'b0;
    @(negedge clk);
    do_reset;

    // R1 reset state
    chk("R1 status", {16'h0, status_word}, 32'h2700);
    chk("R1 run_mode", {31'h0, run_mode}, 32'h0);
    chk("R1 req", {31'h0, mem_req}, 32'h1);
    chk("R1 addr", mem_addr, 32'h0);
    rd(3'd4, v);
    chk("R1 vbr", v, 32'h0);

    // R2 wait states hold the request
    repeat (2) tick;
    chk("R2 hold req", {31'h0, mem_req}, 32'h1);
    chk("R2 hold addr", mem_addr, 32'h0);

    // R4 writes during fetch are ignored
    flag_we = 1'b1; flag_in = 5'h1F;
    wr(3'd7, 32'h0000_0000);
    flag_we = 1'b0;
    chk("R4 status", {16'h0, status_word}, 32'h2700);
    wr(3'd4, 32'h1111_2222);
    rd(3'd4, v);
    chk("R4 vbr", v, 32'h0);

    // R2 fetch order, R3 narrow address
    mem_ack = 1'b1; mem_rdata = 32'h0000_8000;
    tick;
    chk("R2 sp loaded", active_sp, 32'h0000_8000);
    chk("R2 second addr", mem_addr, 32'h4);
    chk("R2 not running", {31'h0, run_mode}, 32'h0);
    mem_rdata = 32'hAB12_3456;
    tick;
    mem_ack = 1'b0;
    chk("R3 narrow pc", prog_ctr, 32'h0012_3456);
    chk("R2 running", {31'h0, run_mode}, 32'h1);
    chk("R2 req dropped", {31'h0, mem_req}, 32'h0);

    // R3 full address on kind 3
    core_kind = 2'd3;
    do_reset;
    fetch(32'h0000_1000, 32'hAB12_3456);
    chk("R3 full pc", prog_ctr, 32'hAB12_3456);
    rd(3'd2, v);
    chk("R8 isp live after reset", v, 32'h0000_1000);

    // R5 status write mask table
    for (int i = 0; i < 6; i++) begin
      core_kind = VEC[i][33:32];
      wr(3'd7, {16'h0, VEC[i][31:16]});
      chk("R5 status mask", {16'h0, status_word}, {16'h0, VEC[i][15:0]});
    end

    // R9 enter interrupt bank, live reloaded
    core_kind = 2'd3;
    wr(3'd7, 32'h2000);
    chk("R9 isp reload", active_sp, 32'h0000_1000);
    wr(3'd0, 32'h100);
    rd(3'd2, v);
    chk("R8 isp live S1M0", v, 32'h100);
    wr(3'd3, 32'h300);
    chk("R8 msp shadow write", active_sp, 32'h100);
    rd(3'd3, v);
    chk("R8 msp shadow read", v, 32'h300);
    wr(3'd1, 32'h200);
    chk("R7 usp shadow S1", active_sp, 32'h100);
    rd(3'd1, v);
    chk("R7 usp shadow read", v, 32'h200);

    // R9 move to master bank
    wr(3'd7, 32'h3000);
    chk("R9 msp loaded", active_sp, 32'h300);
    rd(3'd2, v);
    chk("R8 isp saved when M1", v, 32'h100);
    wr(3'd3, 32'h330);
    chk("R8 msp live S1M1", active_sp, 32'h330);

    // R9 move to user bank
    wr(3'd7, 32'h0000);
    chk("R9 usp loaded", active_sp, 32'h200);
    wr(3'd1, 32'h210);
    chk("R7 usp live S0", active_sp, 32'h210);
    rd(3'd3, v);
    chk("R9 msp saved", v, 32'h330);

    // R5 narrow kind masks M away: interrupt bank
    core_kind = 2'd0;
    wr(3'd7, 32'h3000);
    chk("R5 narrow M dropped", {16'h0, status_word}, 32'h2000);
    chk("R9 isp after narrow write", active_sp, 32'h100);
    rd(3'd1, v);
    chk("R9 usp saved", v, 32'h210);

    // R6 flags
    flag_we = 1'b1; flag_in = 5'h15;
    tick;
    flag_we = 1'b0;
    chk("R6 flag update", {16'h0, status_word}, 32'h2015);
    flag_we = 1'b1; flag_in = 5'h1F;
    wr(3'd7, 32'h2700);
    flag_we = 1'b0;
    chk("R6 status wins", {16'h0, status_word}, 32'h2700);

    // R10 function codes, R11 read select
    wr(3'd5, 32'hFFFF_FFFD);
    rd(3'd5, v);
    chk("R10 sfc", v, 32'h5);
    wr(3'd6, 32'h0000_000A);
    rd(3'd6, v);
    chk("R10 dfc", v, 32'h2);
    wr(3'd4, 32'h1234_5678);
    rd(3'd4, v);
    chk("R11 vbr read", v, 32'h1234_5678);
    rd(3'd7, v);
    chk("R11 status read", v, 32'h2700);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule